// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home node of a full bit-vector directory. For each of a small fixed set of cache blocks it keeps one presence bit per private cache and an exclusive bit. Caches send read, read-for-ownership and upgrade requests over one request port. The controller answers on one response port with a shared grant, an exclusive grant, an upgrade grant or a negative acknowledgement. When other copies must be removed or downgraded, it sends per-cache invalidate messages and collects the acknowledgements before it grants.

Every request to a block passes through this controller, so the controller sets the order of all requests to that block. While a block waits for acknowledgements it is busy. Any request that reaches a busy block is refused with a NACK, and the requestor retries later. Requests to other blocks go ahead as normal. Block data sits in a small internal memory array. An acknowledgement can carry dirty data, and that data is written into the array.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is high, `rsp_valid_o` and all `inv_valid_o` bits are low, and the memory word of block b holds the value b.
- R2: A read (kind 0) to a block that no other cache holds is answered in the cycle after acceptance with an exclusive grant (kind 1). The requestor becomes the sole, exclusive holder.
- R3: A read to a block that other caches share without exclusivity is answered at once with a shared grant (kind 0) and sends no invalidations. The requestor joins the sharers.
- R4: A read to a block that another cache holds exclusively sends that owner an invalidate with `inv_keep_o` = 1, which is a downgrade. The controller answers with a shared grant after the acknowledgement, and both caches are then sharers.
- R5: A read-for-ownership (kind 1) or an upgrade (kind 2) sends an invalidate with `inv_keep_o` = 0 to every other holder. The exclusive grant comes only after all acknowledgements have arrived, and the requestor is then the only holder with the exclusive bit set.
- R6: The number of acknowledgements the controller waits for equals the number of invalidates it sent. A partial set of acknowledgements produces no response, and several acknowledgements may arrive in the same cycle.
- R7: A read-for-ownership or an upgrade from a cache that is already the sole holder is granted at once with no invalidates. A read-for-ownership gets kind 1 and an upgrade gets kind 2.
- R8: An upgrade from a cache whose presence bit is clear is treated as a read-for-ownership and is answered with an exclusive data grant (kind 1).
- R9: A request to a block that is waiting for acknowledgements is answered with a NACK (kind 3, data 0) and leaves the block unchanged. Other blocks continue to be served.
- R10: An acknowledgement naming a block that is not waiting for acknowledgements has no effect on responses, counts or memory.
- R11: An acknowledgement with `ack_dirty_i` set writes its data into the block's memory word. That grant and all later grants for the block return the new value.
- R12: The reserved request kind 3 is answered with a NACK and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_kind_i | input | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 reserved |
| req_src_i | input | SRC_W | Requesting cache index |
| req_blk_i | input | BLK_W | Requested block index |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_kind_o | output | 2 | 0 shared, 1 exclusive, 2 upgrade grant, 3 NACK |
| rsp_dst_o | output | SRC_W | Destination cache |
| rsp_blk_o | output | BLK_W | Block index |
| rsp_data_o | output | DATA_W | Block data (0 for NACK) |
| inv_valid_o | output | NUM_CACHES | Per-cache invalidate valid |
| inv_ready_i | input | NUM_CACHES | Per-cache invalidate taken |
| inv_blk_o | output | BLK_W | Block being invalidated |
| inv_keep_o | output | 1 | 1: downgrade to shared, 0: drop copy |
| ack_valid_i | input | NUM_CACHES | Per-cache acknowledgement |
| ack_blk_i | input | NUM_CACHES*BLK_W | Block named by each acknowledgement |
| ack_dirty_i | input | NUM_CACHES | Acknowledgement carries dirty data |
| ack_data_i | input | NUM_CACHES*DATA_W | Data returned by each acknowledgement |

## Verification
The bench builds the controller with its default four caches, four blocks and 16-bit data. Four caches are enough to reach the sharer sets of one, two and three other holders. That makes the multi-acknowledgement count, same-cycle acknowledgements and partial acknowledgements all observable. Four blocks allow one block to be held busy while a second block completes a downgrade with dirty data, and while a third takes a stray acknowledgement.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;
  typedef enum logic [1:0] {
    REQ_RD  = 2'd0,
    REQ_RDX = 2'd1,
    REQ_UPG = 2'd2,
    REQ_RSV = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    RSP_SHR  = 2'd0,
    RSP_EXC  = 2'd1,
    RSP_UPG  = 2'd2,
    RSP_NACK = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/dir_ack_ctr.sv
module dir_ack_ctr #(
  parameter int unsigned NUM_CACHES = 4,
  parameter int unsigned BLK_W      = 2,
  parameter int unsigned BLK_ID     = 0,
  localparam int unsigned CNT_W     = $clog2(NUM_CACHES + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [CNT_W-1:0]              load_cnt_i,
  input  logic                          clr_i,
  input  logic [NUM_CACHES-1:0]         ack_valid_i,
  input  logic [NUM_CACHES*BLK_W-1:0]   ack_blk_i,
  output logic                          busy_o,
  output logic                          done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hits;
  logic             busy_q;

  always_comb begin
    hits = '0;
    for (int l = 0; l < NUM_CACHES; l++) begin
      if (ack_valid_i[l] && (ack_blk_i[l*BLK_W +: BLK_W] == BLK_W'(BLK_ID)))
        hits = hits + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_cnt_i;
      busy_q <= 1'b1;
    end else begin
      if (clr_i) busy_q <= 1'b0;
      // acks for an idle block are dropped
      if (busy_q) cnt_q <= (hits >= cnt_q) ? '0 : cnt_q - hits;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_cnt_i != '0) && !busy_q);  // R6
  AST_PARTIAL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !load_i && (hits < cnt_q)) |=> !done_o);  // R6
endmodule

// File: rtl/dir_inv_issue.sv
module dir_inv_issue #(
  parameter int unsigned NUM_CACHES = 4,
  parameter int unsigned BLK_W      = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [NUM_CACHES-1:0] tgt_i,
  input  logic [BLK_W-1:0]      blk_i,
  input  logic                  keep_i,
  input  logic [NUM_CACHES-1:0] inv_ready_i,
  output logic [NUM_CACHES-1:0] inv_valid_o,
  output logic [BLK_W-1:0]      inv_blk_o,
  output logic                  inv_keep_o,
  output logic                  idle_o
);
  logic [NUM_CACHES-1:0] pend_q;
  logic [BLK_W-1:0]      blk_q;
  logic                  keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      blk_q  <= '0;
      keep_q <= 1'b0;
    end else if (start_i) begin
      pend_q <= tgt_i;
      blk_q  <= blk_i;
      keep_q <= keep_i;
    end else begin
      pend_q <= pend_q & ~inv_ready_i;
    end
  end

  assign inv_valid_o = pend_q;
  assign inv_blk_o   = blk_q;
  assign inv_keep_o  = keep_q;
  assign idle_o      = (pend_q == '0);

  AST_INV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(inv_valid_o & ~inv_ready_i)) |=>
      ((inv_valid_o & $past(inv_valid_o & ~inv_ready_i)) == $past(inv_valid_o & ~inv_ready_i))
      && $stable(inv_blk_o) && $stable(inv_keep_o));  // R5
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> idle_o);  // R5
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_home_pkg::*;
#(
  parameter int unsigned NUM_CACHES = 4,
  parameter int unsigned NUM_BLOCKS = 4,
  parameter int unsigned DATA_W     = 16,
  localparam int unsigned SRC_W     = $clog2(NUM_CACHES),
  localparam int unsigned BLK_W     = $clog2(NUM_BLOCKS),
  localparam int unsigned CNT_W     = $clog2(NUM_CACHES + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic [1:0]                     req_kind_i,
  input  logic [SRC_W-1:0]               req_src_i,
  input  logic [BLK_W-1:0]               req_blk_i,
  output logic                           rsp_valid_o,
  input  logic                           rsp_ready_i,
  output logic [1:0]                     rsp_kind_o,
  output logic [SRC_W-1:0]               rsp_dst_o,
  output logic [BLK_W-1:0]               rsp_blk_o,
  output logic [DATA_W-1:0]              rsp_data_o,
  output logic [NUM_CACHES-1:0]          inv_valid_o,
  input  logic [NUM_CACHES-1:0]          inv_ready_i,
  output logic [BLK_W-1:0]               inv_blk_o,
  output logic                           inv_keep_o,
  input  logic [NUM_CACHES-1:0]          ack_valid_i,
  input  logic [NUM_CACHES*BLK_W-1:0]    ack_blk_i,
  input  logic [NUM_CACHES-1:0]          ack_dirty_i,
  input  logic [NUM_CACHES*DATA_W-1:0]   ack_data_i
);
  localparam logic [NUM_CACHES-1:0] ONE_OH = NUM_CACHES'(1);

  // directory entry: presence vector + exclusive bit
  logic [NUM_CACHES-1:0] vec_q  [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] excl_q;
  logic [DATA_W-1:0]     mem_q  [NUM_BLOCKS];
  logic [SRC_W-1:0]      pnd_src_q  [NUM_BLOCKS];
  rsp_kind_e             pnd_kind_q [NUM_BLOCKS];

  logic [NUM_BLOCKS-1:0] busy, done, load_blk, clr_blk;

  logic                  rsp_valid_q;
  rsp_kind_e             rsp_kind_q;
  logic [SRC_W-1:0]      rsp_dst_q;
  logic [BLK_W-1:0]      rsp_blk_q;
  logic [DATA_W-1:0]     rsp_data_q;

  logic slot_free, inv_idle, acc;

  // ---------------- per-block ack counters ----------------
  logic [CNT_W-1:0] d_cnt;
  logic             d_inv;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assign load_blk[b] = acc && d_inv && (req_blk_i == BLK_W'(b));
    dir_ack_ctr #(
      .NUM_CACHES(NUM_CACHES), .BLK_W(BLK_W), .BLK_ID(b)
    ) i_ack_ctr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load_blk[b]),
      .load_cnt_i  (d_cnt),
      .clr_i       (clr_blk[b]),
      .ack_valid_i (ack_valid_i),
      .ack_blk_i   (ack_blk_i),
      .busy_o      (busy[b]),
      .done_o      (done[b])
    );

    AST_EXCL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      excl_q[b] |-> $onehot(vec_q[b]));  // R2
  end

  // ---------------- completion pick ----------------
  logic             any_done, cmp_fire;
  logic [BLK_W-1:0] done_idx;

  always_comb begin
    any_done = 1'b0;
    done_idx = '0;
    for (int b = NUM_BLOCKS - 1; b >= 0; b--) begin
      if (done[b]) begin
        any_done = 1'b1;
        done_idx = BLK_W'(b);
      end
    end
  end

  assign slot_free   = !rsp_valid_q || rsp_ready_i;
  assign cmp_fire    = any_done && slot_free;
  assign req_ready_o = slot_free && !any_done && inv_idle;
  assign acc         = req_valid_i && req_ready_o;

  always_comb begin
    clr_blk = '0;
    if (cmp_fire) clr_blk[done_idx] = 1'b1;
  end

  // ---------------- request decision ----------------
  logic [NUM_CACHES-1:0] src_oh, cur_vec, others, d_vec;
  logic                  owns, d_excl, d_upd, d_keep;
  rsp_kind_e             d_kind, d_pkind, gkind;
  req_kind_e             rkind;

  always_comb begin
    rkind   = req_kind_e'(req_kind_i);
    src_oh  = ONE_OH << req_src_i;
    cur_vec = vec_q[req_blk_i];
    others  = cur_vec & ~src_oh;
    owns    = |(cur_vec & src_oh);
    gkind   = (rkind == REQ_UPG && owns) ? RSP_UPG : RSP_EXC;
    d_kind  = RSP_NACK;
    d_pkind = RSP_EXC;
    d_inv   = 1'b0;
    d_keep  = 1'b0;
    d_upd   = 1'b0;
    d_vec   = cur_vec;
    d_excl  = excl_q[req_blk_i];
    d_cnt   = '0;
    for (int l = 0; l < NUM_CACHES; l++) d_cnt = d_cnt + CNT_W'(others[l]);
    if (!busy[req_blk_i]) begin
      unique case (rkind)
        REQ_RD: begin
          if (others == '0) begin
            d_kind = RSP_EXC; d_vec = src_oh; d_excl = 1'b1; d_upd = 1'b1;
          end else if (excl_q[req_blk_i]) begin
            d_inv = 1'b1; d_keep = 1'b1; d_pkind = RSP_SHR;
          end else begin
            d_kind = RSP_SHR; d_vec = cur_vec | src_oh; d_excl = 1'b0; d_upd = 1'b1;
          end
        end
        REQ_RDX, REQ_UPG: begin
          if (others == '0) begin
            d_kind = gkind; d_vec = src_oh; d_excl = 1'b1; d_upd = 1'b1;
          end else begin
            d_inv = 1'b1; d_pkind = gkind;
          end
        end
        default: ;
      endcase
    end
  end

  // ---------------- invalidate issue ----------------
  dir_inv_issue #(
    .NUM_CACHES(NUM_CACHES), .BLK_W(BLK_W)
  ) i_inv_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (acc && d_inv),
    .tgt_i       (others),
    .blk_i       (req_blk_i),
    .keep_i      (d_keep),
    .inv_ready_i (inv_ready_i),
    .inv_valid_o (inv_valid_o),
    .inv_blk_o   (inv_blk_o),
    .inv_keep_o  (inv_keep_o),
    .idle_o      (inv_idle)
  );

  // ---------------- directory + memory state ----------------
  logic [SRC_W-1:0]      cmp_src;
  rsp_kind_e             cmp_kind;
  logic [NUM_CACHES-1:0] cmp_oh;

  assign cmp_src  = pnd_src_q[done_idx];
  assign cmp_kind = pnd_kind_q[done_idx];
  assign cmp_oh   = ONE_OH << cmp_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      excl_q <= '0;
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        vec_q[b]      <= '0;
        mem_q[b]      <= DATA_W'(b);
        pnd_src_q[b]  <= '0;
        pnd_kind_q[b] <= RSP_EXC;
      end
    end else begin
      for (int l = 0; l < NUM_CACHES; l++) begin
        if (ack_valid_i[l] && ack_dirty_i[l] && busy[ack_blk_i[l*BLK_W +: BLK_W]])
          mem_q[ack_blk_i[l*BLK_W +: BLK_W]] <= ack_data_i[l*DATA_W +: DATA_W];
      end
      if (acc && d_upd) begin
        vec_q[req_blk_i]  <= d_vec;
        excl_q[req_blk_i] <= d_excl;
      end
      if (acc && d_inv) begin
        pnd_src_q[req_blk_i]  <= req_src_i;
        pnd_kind_q[req_blk_i] <= d_pkind;
      end
      if (cmp_fire) begin
        if (cmp_kind == RSP_SHR) begin
          vec_q[done_idx]  <= vec_q[done_idx] | cmp_oh;
          excl_q[done_idx] <= 1'b0;
        end else begin
          vec_q[done_idx]  <= cmp_oh;
          excl_q[done_idx] <= 1'b1;
        end
      end
    end
  end

  // ---------------- response slot ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_kind_q  <= RSP_NACK;
      rsp_dst_q   <= '0;
      rsp_blk_q   <= '0;
      rsp_data_q  <= '0;
    end else if (slot_free) begin
      if (cmp_fire) begin
        rsp_valid_q <= 1'b1;
        rsp_kind_q  <= cmp_kind;
        rsp_dst_q   <= cmp_src;
        rsp_blk_q   <= done_idx;
        rsp_data_q  <= mem_q[done_idx];
      end else if (acc && !d_inv) begin
        rsp_valid_q <= 1'b1;
        rsp_kind_q  <= d_kind;
        rsp_dst_q   <= req_src_i;
        rsp_blk_q   <= req_blk_i;
        rsp_data_q  <= (d_kind == RSP_NACK) ? '0 : mem_q[req_blk_i];
      end else begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_kind_o  = rsp_kind_q;
  assign rsp_dst_o   = rsp_dst_q;
  assign rsp_blk_o   = rsp_blk_q;
  assign rsp_data_o  = rsp_data_q;

  AST_NACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && busy[req_blk_i]) |=> rsp_valid_o && (rsp_kind_o == RSP_NACK));  // R9
  AST_GRANT_SOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && (rsp_kind_o == RSP_EXC || rsp_kind_o == RSP_UPG)) |->
      excl_q[rsp_blk_o] && (vec_q[rsp_blk_o] == (ONE_OH << rsp_dst_o)));  // R5
  AST_SHARED_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == RSP_SHR) |->
      !excl_q[rsp_blk_o] && vec_q[rsp_blk_o][rsp_dst_o]);  // R3
  AST_RSV_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && rkind == REQ_RSV) |=> rsp_valid_o && (rsp_kind_o == RSP_NACK));  // R12
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> rsp_valid_o && $stable(rsp_kind_o) && $stable(rsp_dst_o));  // R9
endmodule

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
  localparam int P = 4, NB = 4, DW = 16, SW = 2, BW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = '0;
  logic [SW-1:0] req_src = '0;
  logic [BW-1:0] req_blk = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [1:0] rsp_kind;
  logic [SW-1:0] rsp_dst;
  logic [BW-1:0] rsp_blk;
  logic [DW-1:0] rsp_data;
  logic [P-1:0] inv_valid, inv_ready = '1;
  logic [BW-1:0] inv_blk;
  logic inv_keep;
  logic [P-1:0] ack_valid = '0, ack_dirty = '0;
  logic [P*BW-1:0] ack_blk = '0;
  logic [P*DW-1:0] ack_data = '0;

  always #2 clk = ~clk;

  dir_home_ctrl #(.NUM_CACHES(P), .NUM_BLOCKS(NB), .DATA_W(DW)) i_dir_home_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_kind_i(req_kind),
    .req_src_i(req_src), .req_blk_i(req_blk),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_kind_o(rsp_kind),
    .rsp_dst_o(rsp_dst), .rsp_blk_o(rsp_blk), .rsp_data_o(rsp_data),
    .inv_valid_o(inv_valid), .inv_ready_i(inv_ready), .inv_blk_o(inv_blk),
    .inv_keep_o(inv_keep),
    .ack_valid_i(ack_valid), .ack_blk_i(ack_blk), .ack_dirty_i(ack_dirty),
    .ack_data_i(ack_data)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [P-1:0] c_inv;
  logic c_keep;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input int s, input int b);
    @(negedge clk);
    req_kind = k; req_src = SW'(s); req_blk = BW'(b); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    c_inv = inv_valid; c_keep = inv_keep;
  endtask

  task automatic ack(input logic [P-1:0] m, input int b, input logic dirty, input logic [DW-1:0] d);
    ack_valid = m;
    for (int l = 0; l < P; l++) begin
      ack_blk[l*BW +: BW] = BW'(b);
      ack_dirty[l] = dirty;
      ack_data[l*DW +: DW] = d;
    end
    @(posedge clk); #1 ack_valid = '0; ack_dirty = '0;
  endtask

  task automatic expect_rsp(input string req, input logic [1:0] k, input int d, input int b, input logic [DW-1:0] data);
    for (int i = 0; i < 12 && !rsp_valid; i++) @(negedge clk);
    check(rsp_valid, req, {31'd0, rsp_valid}, 1);
    check(rsp_kind == k, req, rsp_kind, k);
    check(rsp_dst == SW'(d), req, rsp_dst, d);
    check(rsp_blk == BW'(b), req, rsp_blk, b);
    check(rsp_data == data, req, rsp_data, data);
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(!rsp_valid, req, {31'd0, rsp_valid}, 0);
    end
  endtask

  // {kind, src, blk, exp_kind, exp_inv_mask, exp_keep}
  localparam logic [12:0] VEC [15] = '{
    {2'd0, 2'd0, 2'd0, 2'd1, 4'b0000, 1'b0},  // R2
    {2'd0, 2'd1, 2'd0, 2'd0, 4'b0001, 1'b1},  // R4
    {2'd0, 2'd2, 2'd0, 2'd0, 4'b0000, 1'b0},  // R3
    {2'd1, 2'd3, 2'd0, 2'd1, 4'b0111, 1'b0},  // R5 R6
    {2'd2, 2'd3, 2'd0, 2'd2, 4'b0000, 1'b0},  // R7
    {2'd0, 2'd1, 2'd1, 2'd1, 4'b0000, 1'b0},  // R2
    {2'd0, 2'd2, 2'd1, 2'd0, 4'b0010, 1'b1},  // R4
    {2'd2, 2'd1, 2'd1, 2'd2, 4'b0100, 1'b0},  // R5
    {2'd2, 2'd0, 2'd1, 2'd1, 4'b0010, 1'b0},  // R8
    {2'd0, 2'd2, 2'd2, 2'd1, 4'b0000, 1'b0},  // R2
    {2'd1, 2'd2, 2'd2, 2'd1, 4'b0000, 1'b0},  // R7
    {2'd3, 2'd0, 2'd3, 2'd3, 4'b0000, 1'b0},  // R12
    {2'd0, 2'd0, 2'd3, 2'd1, 4'b0000, 1'b0},  // R2
    {2'd0, 2'd1, 2'd3, 2'd0, 4'b0001, 1'b1},  // R4
    {2'd1, 2'd0, 2'd3, 2'd1, 4'b0010, 1'b0}   // R5
  };

  initial begin
    #10000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready", {31'd0, req_ready}, 1);
    check(!rsp_valid, "R1 rsp idle", {31'd0, rsp_valid}, 0);
    check(inv_valid == '0, "R1 inv idle", inv_valid, 0);

    for (int v = 0; v < 15; v++) begin
      logic [1:0] k, ek;
      int s, b;
      logic [P-1:0] m;
      k = VEC[v][12:11]; s = VEC[v][10:9]; b = VEC[v][8:7];
      ek = VEC[v][6:5]; m = VEC[v][4:1];
      send(k, s, b);
      check(c_inv == m, $sformatf("R5 vec%0d inv mask", v), c_inv, m);
      if (m != '0) begin
        check(c_keep == VEC[v][0], $sformatf("R4 vec%0d keep", v), c_keep, VEC[v][0]);
        check(!rsp_valid, $sformatf("R6 vec%0d early rsp", v), rsp_valid, 0);
        ack(m, b, 1'b0, '0);
      end
      expect_rsp($sformatf("R1 R2 vec%0d", v), ek, s, b, (ek == 2'd3) ? '0 : DW'(b));
    end
    // state: b0={3}x b1={0}x b2={2}x b3={0}x

    // R9: block 2 held busy, NACK to it, block 1 served meanwhile
    send(2'd1, 1, 2);
    check(c_inv == 4'b0100, "R9 busy setup inv", c_inv, 4'b0100);
    send(2'd0, 3, 2);
    expect_rsp("R9 nack", 2'd3, 3, 2, '0);
    send(2'd0, 3, 1);
    check(c_inv == 4'b0001 && c_keep, "R4 downgrade inv", {c_keep, c_inv}, 5'b10001);
    ack(4'b0001, 1, 1'b1, 16'hBEEF);
    expect_rsp("R11 dirty grant", 2'd0, 3, 1, 16'hBEEF);
    ack(4'b0100, 2, 1'b0, '0);
    expect_rsp("R9 busy completes", 2'd1, 1, 2, 16'd2);

    // R10: stray dirty ack on idle block 0
    @(negedge clk);
    ack(4'b1000, 0, 1'b1, 16'h1234);
    expect_quiet("R10 stray ack quiet", 4);
    send(2'd0, 3, 0);
    check(c_inv == '0, "R10 no inv", c_inv, 0);
    expect_rsp("R10 memory untouched", 2'd1, 3, 0, 16'd0);

    // R3 + R11: block 1 now {0,3} shared
    send(2'd0, 2, 1);
    check(c_inv == '0, "R3 no inv", c_inv, 0);
    expect_rsp("R3 R11 shared keeps data", 2'd0, 2, 1, 16'hBEEF);

    // R6: partial acks hold the grant
    send(2'd1, 1, 1);
    check(c_inv == 4'b1101 && !c_keep, "R5 inv three", {c_keep, c_inv}, 5'b01101);
    ack(4'b0001, 1, 1'b0, '0);
    expect_quiet("R6 partial ack", 4);
    ack(4'b1100, 1, 1'b0, '0);
    expect_rsp("R6 all acks", 2'd1, 1, 1, 16'hBEEF);

    // R7: upgrade by sole owner
    send(2'd2, 1, 1);
    check(c_inv == '0, "R7 no inv", c_inv, 0);
    expect_rsp("R7 upgrade grant", 2'd2, 1, 1, 16'hBEEF);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule